// File: doc/BRIEF.md
# Radio SPI Command Engine

The engine is an SPI master that sends opcode-led commands to a radio transceiver. It handles the transceiver's BUSY handshake and builds the frame that each kind of command needs. A host presents an opcode, a command kind, a 16-bit address and a payload byte count on a command port. The engine waits until the transceiver drops BUSY, and it gives up waiting after a timeout of `TIMEOUT_MS` milliseconds. It then pulls chip select low and shifts the whole frame in SPI mode 0, most significant bit first. The frame holds the address bytes and the dummy status bytes that the command kind calls for.

Outgoing payload bytes come from the host through a valid/ready stream. Bytes that return in the payload phase of a read go back to the host through a second valid/ready stream. Each frame ends with a one-cycle done pulse. The SPI clock is the system clock divided by `2*DIV_HALF`. The engine does not interpret the commands it carries.

Top module: `radio_cmd_engine`

## Requirements
- R1: A command is taken on a cycle where `cmdValid` and `cmdReady` are both high. `cmdReady` is high only while the engine is idle, and it is never high while chip select is low.
- R2: After a command is taken, `csN` stays high while `busy` is high. When `busy` is seen low in a wait cycle, `csN` falls at the next clock edge.
- R3: If `busy` stays high, the frame starts anyway once `TIMEOUT_MS*CYC_PER_MS` wait cycles have passed. `csN` falls at the edge after the wait counter reaches that limit.
- R4: `csN` stays low from the first byte to the last byte of the frame. `done` is high for exactly one cycle, in the last cycle of the frame, and `csN` is high in the cycle after `done`.
- R5: The SPI format is mode 0. `sclk` is low whenever `csN` is high, `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge. Bytes go out MSB first, and one `sclk` period is `2*DIV_HALF` system clocks.
- R6: Register write (`cmdType`=2) sends the opcode, `cmdAddr[15:8]`, `cmdAddr[7:0]`, then `cmdLen` bytes from the transmit stream.
- R7: Register read (`cmdType`=3) sends the opcode, `cmdAddr[15:8]`, `cmdAddr[7:0]` and one 0x00 dummy byte. It then sends `cmdLen` bytes of 0x00 and returns each byte received during them on the receive stream.
- R8: Buffer write (`cmdType`=4) sends the opcode, the start offset `cmdAddr[7:0]`, then `cmdLen` bytes from the transmit stream.
- R9: Buffer read (`cmdType`=5) sends the opcode, `cmdAddr[7:0]` and one 0x00 dummy byte, then reads `cmdLen` bytes.
- R10: Generic read (`cmdType`=1) sends the opcode and one 0x00 status byte, then reads `cmdLen` bytes.
- R11: Generic write (`cmdType`=0) sends the opcode, then `cmdLen` bytes from the transmit stream, with no dummy byte. A `cmdLen` of 0 gives a frame of only the opcode.
- R12: A transmit byte is taken when `txValid` and `txReady` are both high. While no byte is offered, the frame pauses with `sclk` low. A received byte is held on `rxData` with `rxValid` high until `rxReady` is seen, and no bit shifts in that time.
- R13: After reset, `csN`=1, `sclk`=0, `cmdReady`=1, `done`=0, `txReady`=0 and `rxValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdType | input | 3 | Command kind (0 gen write, 1 gen read, 2 reg write, 3 reg read, 4 buf write, 5 buf read) |
| cmdOpcode | input | 8 | First byte of the frame |
| cmdAddr | input | 16 | Register address, or buffer start offset in the low byte |
| cmdLen | input | LEN_W | Number of payload bytes |
| txValid | input | 1 | Transmit payload byte offered |
| txReady | output | 1 | Engine takes a transmit byte |
| txData | input | 8 | Transmit payload byte |
| rxValid | output | 1 | Received payload byte available |
| rxReady | input | 1 | Host takes the received byte |
| rxData | output | 8 | Received payload byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | input | 1 | Transceiver BUSY line |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| csN | output | 1 | SPI chip select, active low |

## Verification
Two events can land in the same cycle: BUSY dropping and the wait timeout expiring. Directed commands release BUSY one cycle before the expiry cycle and exactly on it. A third command never releases BUSY at all. In each case the cycle in which chip select falls is compared with the expected cycle, `min(hold+2, limit+2)` counted from acceptance, and the frame captured afterwards must still be byte-exact. Random commands of every kind with random BUSY holds, stream gaps and receive stalls cover the framing rules, and their expected bytes come from a bench model of each frame layout.

// File: rtl/rce_pkg.sv
`timescale 1ns/1ps
package rce_pkg;

  localparam logic [2:0] KIND_GEN_WR = 3'd0;
  localparam logic [2:0] KIND_GEN_RD = 3'd1;
  localparam logic [2:0] KIND_REG_WR = 3'd2;
  localparam logic [2:0] KIND_REG_RD = 3'd3;
  localparam logic [2:0] KIND_BUF_WR = 3'd4;
  localparam logic [2:0] KIND_BUF_RD = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadByte;
    logic [7:0] byteVal;
    logic       clrWait;
    logic       runWait;
  } dpCtrl_t;

  // bytes sent before the payload phase
  function automatic logic [2:0] hdrLen(input logic [2:0] kind);
    case (kind)
      KIND_GEN_RD: hdrLen = 3'd2;
      KIND_REG_WR: hdrLen = 3'd3;
      KIND_REG_RD: hdrLen = 3'd4;
      KIND_BUF_WR: hdrLen = 3'd2;
      KIND_BUF_RD: hdrLen = 3'd3;
      default:     hdrLen = 3'd1;
    endcase
  endfunction

  function automatic logic isReadKind(input logic [2:0] kind);
    isReadKind = (kind == KIND_GEN_RD) || (kind == KIND_REG_RD) || (kind == KIND_BUF_RD);
  endfunction

  function automatic logic [7:0] hdrByte(input logic [2:0] kind, input logic [7:0] op,
                                         input logic [15:0] addr, input logic [1:0] idx);
    logic isReg, isBuf;
    isReg = (kind == KIND_REG_WR) || (kind == KIND_REG_RD);
    isBuf = (kind == KIND_BUF_WR) || (kind == KIND_BUF_RD);
    if (idx == 2'd0)               hdrByte = op;
    else if (isReg && idx == 2'd1) hdrByte = addr[15:8];
    else if (isReg && idx == 2'd2) hdrByte = addr[7:0];
    else if (isBuf && idx == 2'd1) hdrByte = addr[7:0];
    else                           hdrByte = 8'h00;
  endfunction

endpackage

// File: rtl/rce_datapath.sv
`timescale 1ns/1ps
module rce_datapath
  import rce_pkg::*;
#(
  parameter int DIV_HALF   = 4,
  parameter int WAIT_LIMIT = 10000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctl,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byteDone,
  output logic [7:0] rxByte,
  output logic       waitExpired
);
  localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int WC_W = $clog2(WAIT_LIMIT + 1);

  logic [7:0]      txSh, rxSh;
  logic [2:0]      bitCnt;
  logic [HC_W-1:0] halfCnt;
  logic            active, sclkQ, doneQ;
  logic [WC_W-1:0] waitCnt;
  logic            halfEnd;

  assign halfEnd = (halfCnt == HC_W'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0; rxSh <= '0; bitCnt <= '0; halfCnt <= '0;
      active <= 1'b0; sclkQ <= 1'b0; doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.loadByte) begin
        txSh    <= ctl.byteVal;
        bitCnt  <= '0;
        halfCnt <= '0;
        sclkQ   <= 1'b0;
        active  <= 1'b1;
      end else if (active) begin
        if (halfEnd) begin
          halfCnt <= '0;
          if (!sclkQ) begin
            sclkQ <= 1'b1;
            rxSh  <= {rxSh[6:0], miso};
          end else begin
            sclkQ  <= 1'b0;
            txSh   <= {txSh[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active <= 1'b0;
              doneQ  <= 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + HC_W'(1);
        end
      end
    end
  end

  assign waitExpired = (waitCnt == WC_W'(WAIT_LIMIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          waitCnt <= '0;
    else if (ctl.clrWait)               waitCnt <= '0;
    else if (ctl.runWait && !waitExpired) waitCnt <= waitCnt + WC_W'(1);
  end

  assign sclk     = sclkQ;
  assign mosi     = txSh[7];
  assign byteDone = doneQ;
  assign rxByte   = rxSh;
endmodule

// File: rtl/rce_ctrl.sv
`timescale 1ns/1ps
module rce_ctrl
  import rce_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [2:0]       cmdType,
  input  logic [7:0]       cmdOpcode,
  input  logic [15:0]      cmdAddr,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             txValid,
  output logic             txReady,
  input  logic [7:0]       txData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             done,
  input  logic             busy,
  output logic             csN,
  output dpCtrl_t          ctl,
  input  logic             byteDone,
  input  logic             waitExpired
);
  localparam int IDX_W = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SEL, S_SHIFT, S_RXOUT, S_END} state_e;

  state_e           state, stateNext;
  logic [2:0]       kindQ;
  logic [7:0]       opQ;
  logic [15:0]      addrQ;
  logic [LEN_W-1:0] lenQ;
  logic [IDX_W-1:0] byteIdx, hdrCnt, totalCnt;
  logic             csQ, inHdr, inPay, rdKind;

  always_comb begin
    hdrCnt   = IDX_W'(hdrLen(kindQ));
    totalCnt = hdrCnt + IDX_W'(lenQ);
    inHdr    = byteIdx < hdrCnt;
    inPay    = !inHdr && (byteIdx < totalCnt);
    rdKind   = isReadKind(kindQ);
  end

  assign cmdReady = (state == S_IDLE);
  assign txReady  = (state == S_SEL) && inPay && !rdKind;
  assign rxValid  = (state == S_RXOUT);
  assign done     = (state == S_END);
  assign csN      = csQ;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.clrWait = (state == S_IDLE);
    ctl.runWait = (state == S_WAIT);
    case (state)
      S_IDLE:  if (cmdValid) stateNext = S_WAIT;
      S_WAIT:  if (!busy || waitExpired) stateNext = S_SEL;
      S_SEL: begin
        if (inHdr) begin
          ctl.loadByte = 1'b1;
          ctl.byteVal  = hdrByte(kindQ, opQ, addrQ, byteIdx[1:0]);
          stateNext    = S_SHIFT;
        end else if (inPay) begin
          if (rdKind) begin
            ctl.loadByte = 1'b1;
            ctl.byteVal  = 8'h00;
            stateNext    = S_SHIFT;
          end else if (txValid) begin
            ctl.loadByte = 1'b1;
            ctl.byteVal  = txData;
            stateNext    = S_SHIFT;
          end
        end else begin
          stateNext = S_END;
        end
      end
      S_SHIFT: if (byteDone) stateNext = (rdKind && byteIdx > hdrCnt) ? S_RXOUT : S_SEL;
      S_RXOUT: if (rxReady) stateNext = S_SEL;
      S_END:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; csQ <= 1'b1; kindQ <= '0; opQ <= '0;
      addrQ <= '0; lenQ <= '0; byteIdx <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && cmdValid) begin
        kindQ   <= cmdType;
        opQ     <= cmdOpcode;
        addrQ   <= cmdAddr;
        lenQ    <= cmdLen;
        byteIdx <= '0;
      end
      if (ctl.loadByte) byteIdx <= byteIdx + IDX_W'(1);
      if (state == S_WAIT && stateNext == S_SEL) csQ <= 1'b0;
      if (state == S_END) csQ <= 1'b1;
    end
  end
endmodule

// File: rtl/radio_cmd_engine.sv
`timescale 1ns/1ps
module radio_cmd_engine
  import rce_pkg::*;
#(
  parameter int DIV_HALF   = 4,
  parameter int LEN_W      = 9,
  parameter int CYC_PER_MS = 100000,
  parameter int TIMEOUT_MS = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [2:0]       cmdType,
  input  logic [7:0]       cmdOpcode,
  input  logic [15:0]      cmdAddr,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             txValid,
  output logic             txReady,
  input  logic [7:0]       txData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic [7:0]       rxData,
  output logic             done,
  input  logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             csN
);
  localparam int WAIT_LIMIT = CYC_PER_MS * TIMEOUT_MS;

  dpCtrl_t ctl;
  logic    byteDone, waitExpired;

  rce_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdType(cmdType), .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .done(done), .busy(busy), .csN(csN),
    .ctl(ctl), .byteDone(byteDone), .waitExpired(waitExpired)
  );

  rce_datapath #(.DIV_HALF(DIV_HALF), .WAIT_LIMIT(WAIT_LIMIT)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .miso(miso), .sclk(sclk), .mosi(mosi),
    .byteDone(byteDone), .rxByte(rxData), .waitExpired(waitExpired)
  );
endmodule

// File: rtl/rce_checker.sv
`timescale 1ns/1ps
module rce_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdReady,
  input logic       done,
  input logic       csN,
  input logic       sclk,
  input logic       mosi,
  input logic       rxValid,
  input logic       rxReady,
  input logic [7:0] rxData
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R5
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R5
  AST_CS_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !done) |=> !csN); // R4
  AST_CS_RISE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> csN); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> csN); // R1
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData))); // R12
  AST_RX_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (!sclk && !csN)); // R12
endmodule

bind radio_cmd_engine rce_checker u_rceChecker (.*);

// File: tb/test_radio_cmd_engine.sv
`timescale 1ns/1ps
module test_radio_cmd_engine;
  localparam int DIV_HALF = 2;
  localparam int LEN_W    = 9;
  localparam int CPM      = 20;
  localparam int TMO      = 100;
  localparam int LIMIT    = CPM * TMO;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdReady;
  logic [2:0] cmdType = 0;
  logic [7:0] cmdOpcode = 0;
  logic [15:0] cmdAddr = 0;
  logic [LEN_W-1:0] cmdLen = 0;
  logic txValid = 0, txReady;
  logic [7:0] txData = 0;
  logic rxValid, rxReady = 0;
  logic [7:0] rxData;
  logic done, busy = 0, sclk, mosi, miso, csN;

  radio_cmd_engine #(.DIV_HALF(DIV_HALF), .LEN_W(LEN_W), .CYC_PER_MS(CPM), .TIMEOUT_MS(TMO))
  i_radio_cmd_engine (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    finishRun();
  end

  // slave response for frame byte k
  function automatic logic [7:0] respOf(input int k);
    respOf = 8'(8'h5A ^ (k * 29));
  endfunction

  int sByte = 0, sBit = 0;
  logic [7:0] curResp;
  always @(negedge sclk or posedge csN) begin
    if (csN) begin sByte = 0; sBit = 0; end
    else begin
      sBit++;
      if (sBit == 8) begin sBit = 0; sByte++; end
    end
  end
  assign curResp = respOf(sByte);
  assign miso = curResp[3'(7 - sBit)];

  // MOSI capture, MSB first
  logic [7:0] capB [0:299];
  logic [7:0] capSh = 0;
  int capBit = 0, capN = 0, riseCount = 0;
  time lastRise = 0, firstPeriod = 0;
  always @(posedge sclk or negedge csN) begin
    if (!sclk) begin capBit = 0; capN = 0; riseCount = 0; firstPeriod = 0; end
    else begin
      if (riseCount == 1) firstPeriod = $time - lastRise;
      lastRise = $time;
      riseCount++;
      capSh = {capSh[6:0], mosi};
      capBit++;
      if (capBit == 8) begin capB[capN] = capSh; capN++; capBit = 0; end
    end
  end

  logic [7:0] pay [0:15];
  logic [7:0] rxGot [0:15];
  logic [7:0] expB [0:31];
  int expN = 0, expHdr = 0;

  function automatic string reqOf(input int t);
    case (t)
      0: reqOf = "R11";
      1: reqOf = "R10";
      2: reqOf = "R6";
      3: reqOf = "R7";
      4: reqOf = "R8";
      default: reqOf = "R9";
    endcase
  endfunction

  function automatic bit isRd(input int t);
    isRd = (t == 1) || (t == 3) || (t == 5);
  endfunction

  task automatic buildExp(input int t, input logic [7:0] op, input logic [15:0] ad, input int n);
    int k;
    expB[0] = op; k = 1;
    if (t == 2 || t == 3) begin expB[1] = ad[15:8]; expB[2] = ad[7:0]; k = 3; end
    else if (t == 4 || t == 5) begin expB[1] = ad[7:0]; k = 2; end
    if (isRd(t)) begin expB[k] = 8'h00; k++; end
    expHdr = k;
    for (int i = 0; i < n; i++) expB[k + i] = isRd(t) ? 8'h00 : pay[i];
    expN = k + n;
  endtask

  function automatic int expWait(input int hold);
    expWait = (hold + 2 < LIMIT + 2) ? hold + 2 : LIMIT + 2;
  endfunction

  task automatic runCmd(input int t, input logic [7:0] op, input logic [15:0] ad, input int n,
                        input int hold, input int gapMax, input int fixedGap, input bit probe);
    int waitC = 0;
    bit finished = 0, readyInFrame = 0, csAfter = 0, bytesOk = 1, rxOk = 1;
    int firstBad = 0;
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
    buildExp(t, op, ad, n);
    @(negedge clk);
    if (hold > 0) busy = 1;
    cmdValid = 1; cmdType = 3'(t); cmdOpcode = op; cmdAddr = ad; cmdLen = LEN_W'(n);
    #1;
    while (!cmdReady) begin @(negedge clk); #1; end
    @(negedge clk);
    cmdValid = 0;
    fork
      begin
        if (hold > 0) begin repeat (hold) @(negedge clk); busy = 0; end
      end
      begin
        waitC = 1;
        while (csN) begin @(negedge clk); waitC++; end
      end
      begin
        if (!isRd(t)) for (int i = 0; i < n; i++) begin
          repeat ((fixedGap > 0 && i == 0) ? fixedGap : int'($urandom % (gapMax + 1))) @(negedge clk);
          txValid = 1; txData = pay[i];
          forever begin #1; if (txReady) break; @(negedge clk); end
          @(negedge clk);
          txValid = 0;
        end
      end
      begin
        if (isRd(t)) for (int i = 0; i < n; i++) begin
          repeat ((fixedGap > 0 && i == 0) ? fixedGap : int'($urandom % (gapMax + 1))) @(negedge clk);
          rxReady = 1;
          forever begin #1; if (rxValid) break; @(negedge clk); end
          rxGot[i] = rxData;
          @(negedge clk);
          rxReady = 0;
        end
      end
      begin
        forever begin
          @(negedge clk);
          if (!csN && cmdReady) readyInFrame = 1;
          if (done) break;
        end
        @(negedge clk);
        csAfter = csN;
        finished = 1;
      end
      begin
        if (probe) begin
          repeat (150) @(negedge clk);
          if (isRd(t)) begin
            check(rxValid == 1'b1, "R12", int'(rxValid), 1);
            check(rxData == respOf(expHdr), "R12", int'(rxData), int'(respOf(expHdr)));
            check(riseCount == 8 * (expHdr + 1) && !sclk, "R12", riseCount, 8 * (expHdr + 1));
          end else begin
            check(riseCount == 8 * expHdr && !sclk, "R12", riseCount, 8 * expHdr);
          end
        end
      end
    join
    check(waitC == expWait(hold), (hold >= LIMIT) ? "R3" : "R2", waitC, expWait(hold));
    check(capN == expN, reqOf(t), capN, expN);
    for (int i = 0; i < expN; i++)
      if (bytesOk && capB[i] !== expB[i]) begin bytesOk = 0; firstBad = i; end
    check(bytesOk, reqOf(t), int'(capB[firstBad]), int'(expB[firstBad]));
    if (isRd(t)) begin
      for (int i = 0; i < n; i++)
        if (rxOk && rxGot[i] !== respOf(expHdr + i)) begin rxOk = 0; firstBad = i; end
      check(rxOk, reqOf(t), int'(rxGot[firstBad]), int'(respOf(expHdr + firstBad)));
    end
    check(csAfter == 1'b1, "R4", int'(csAfter), 1);
    check(!readyInFrame, "R1", int'(readyInFrame), 0);
    check(firstPeriod == time'(20 * DIV_HALF), "R5", int'(firstPeriod), 20 * DIV_HALF);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    check(csN == 1'b1, "R13", int'(csN), 1);
    check(sclk == 1'b0, "R13", int'(sclk), 0);
    check(cmdReady == 1'b1, "R13", int'(cmdReady), 1);
    check(done == 1'b0 && txReady == 1'b0 && rxValid == 1'b0, "R13",
          int'({done, txReady, rxValid}), 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // directed framing, one per kind
    runCmd(0, 8'h84, 16'h0000, 0, 0, 0, 0, 0);   // R11 opcode only
    runCmd(0, 8'h8A, 16'h0000, 1, 0, 0, 0, 0);   // R11
    runCmd(1, 8'h12, 16'h0000, 2, 0, 1, 0, 0);   // R10
    runCmd(2, 8'h0D, 16'h08AC, 1, 0, 1, 0, 0);   // R6
    runCmd(3, 8'h1D, 16'h0740, 1, 0, 1, 0, 0);   // R7
    runCmd(4, 8'h0E, 16'h0010, 4, 0, 2, 0, 0);   // R8
    runCmd(5, 8'h1E, 16'h0080, 3, 0, 2, 0, 0);   // R9
    // busy handshake and timeout
    runCmd(2, 8'h0D, 16'h1234, 1, 37, 0, 0, 0);          // R2
    runCmd(0, 8'h80, 16'h0000, 1, LIMIT - 1, 0, 0, 0);   // R2 release just before expiry
    runCmd(0, 8'h80, 16'h0000, 1, LIMIT, 0, 0, 0);       // R3 release on expiry
    runCmd(1, 8'h15, 16'h0000, 1, LIMIT + 500, 0, 0, 0); // R3 busy stuck
    // stalls on both streams
    runCmd(0, 8'h8E, 16'h0000, 1, 0, 0, 200, 1);  // R12 tx stall
    runCmd(1, 8'h13, 16'h0000, 1, 0, 0, 200, 1);  // R12 rx stall
    // random commands
    for (int it = 0; it < 40; it++) begin
      int t, n, hold;
      t = int'($urandom % 6);
      n = int'($urandom % 7);
      hold = ($urandom % 3 == 0) ? int'($urandom % 50) : 0;
      runCmd(t, 8'($urandom), 16'($urandom), n, hold, 3, 0, 0);
    end
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule